// File: doc/BRIEF.md
# Explicit Register Rename Unit

This unit translates architectural register numbers into physical register numbers drawn from a larger pool. It holds a speculative map table, a committed copy of that table, and a free pool of physical registers kept as one bit per register. Each accepted rename returns the physical registers for two sources. For an instruction that writes a register, it also returns a newly allocated physical register and the mapping that this destination replaces.

The replaced mapping travels with the instruction down the pipeline. When the instruction commits, the retirement logic sends that old register back on the commit port, and the unit returns it to the free pool. Commit also records the new mapping in the committed table. A flush puts the committed table back into the speculative table in a single cycle. In the same cycle it rebuilds the free pool as every physical register that the committed table does not reference.

The rename port uses valid/ready. A rename is accepted on a rising clock edge when `ren_valid` and `ren_ready` are both high. `ren_ready` does not depend on `ren_valid` or on any payload field. The lookup results on the rename port are combinational from the current state. They are meaningful in the cycle the request is presented. Commit and flush are plain control inputs. Commits must arrive in program order, at most one per cycle.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. Physical registers ARCH_REGS through PHYS_REGS-1 are free.
- R2: An accepted rename with `ren_dst_en` high allocates the lowest-numbered free physical register and returns it on `ren_pdst`. Directly after reset the first such rename returns ARCH_REGS.
- R3: `ren_pold` returns the mapping that the destination held before this rename. The destination entry then takes the new register.
- R4: Source lookups use the table as it stood before the same cycle's destination update. A source equal to the destination returns the old mapping.
- R5: An accepted rename with `ren_dst_en` low allocates nothing and changes no mapping.
- R6: `ren_ready` is low whenever the free pool is empty or `flush` is high, and high otherwise.
- R7: A commit with `cmt_dst_en` high returns `cmt_pold` to the free pool at the next edge, where a later rename can allocate it. It also records `cmt_pdst` as the committed mapping of `cmt_dst`.
- R8: A flush copies the committed table into the speculative table at one edge. A commit in the same cycle is included in the copy.
- R9: After a flush, exactly the registers that the committed table does not reference are free, so PHYS_REGS-ARCH_REGS renames fit before `ren_ready` falls.
- R10: A request presented while `ren_ready` is low has no effect on any mapping or on the free pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_src_a | input | AW | First source architectural register |
| ren_src_b | input | AW | Second source architectural register |
| ren_dst_en | input | 1 | Instruction writes a destination |
| ren_dst | input | AW | Destination architectural register |
| ren_psrc_a | output | PW | Physical register for first source |
| ren_psrc_b | output | PW | Physical register for second source |
| ren_pdst | output | PW | Newly allocated physical register |
| ren_pold | output | PW | Previous mapping of the destination |
| cmt_valid | input | 1 | An instruction commits this cycle |
| cmt_dst_en | input | 1 | Committing instruction has a destination |
| cmt_dst | input | AW | Its destination architectural register |
| cmt_pdst | input | PW | Physical register it was given |
| cmt_pold | input | PW | Physical register it replaced, to be freed |
| flush | input | 1 | Restore the committed state |

## Verification
The hardest situation to reach is a flush that arrives with a deep speculative history: the free pool is fully drained, several renames are uncommitted, and a commit lands in the flush cycle itself. Only then does the rebuild have to reclaim many registers that are still referenced by uncommitted work. The directed sequence drains the pool until `ready` falls, commits one instruction, and then flushes. A long random phase follows that mixes renames, in-order commits and occasional flushes. A bench model of both tables and the free pool predicts every lookup and allocation.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int DEF_ARCH_REGS = 32;
  localparam int DEF_PHYS_REGS = 64;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AW-1:0]                 rd_a,
  input  logic [AW-1:0]                 rd_b,
  input  logic [AW-1:0]                 rd_d,
  output logic [PW-1:0]                 val_a,
  output logic [PW-1:0]                 val_b,
  output logic [PW-1:0]                 val_d,
  input  logic                          spec_we,
  input  logic [AW-1:0]                 spec_idx,
  input  logic [PW-1:0]                 spec_val,
  input  logic                          cmt_we,
  input  logic [AW-1:0]                 cmt_idx,
  input  logic [PW-1:0]                 cmt_val,
  input  logic                          restore,
  output logic [ARCH_REGS-1:0][PW-1:0]  spec_map,
  output logic [ARCH_REGS-1:0][PW-1:0]  cmt_map,
  output logic [ARCH_REGS-1:0][PW-1:0]  cmt_map_next
);
  logic [ARCH_REGS-1:0][PW-1:0] spec_q, cmt_q;

  // reads see state before this cycle's update
  assign val_a = spec_q[rd_a];
  assign val_b = spec_q[rd_b];
  assign val_d = spec_q[rd_d];

  always_comb begin
    cmt_map_next = cmt_q;
    if (cmt_we) cmt_map_next[cmt_idx] = cmt_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) begin
        spec_q[i] <= PW'(i);
        cmt_q[i]  <= PW'(i);
      end
    end else begin
      cmt_q <= cmt_map_next;
      if (restore)      spec_q <= cmt_map_next;
      else if (spec_we) spec_q[spec_idx] <= spec_val;
    end
  end

  assign spec_map = spec_q;
  assign cmt_map  = cmt_q;
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64,
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_en,
  output logic [PW-1:0]                 alloc_idx,
  output logic                          any_free,
  input  logic                          free_en,
  input  logic [PW-1:0]                 free_idx,
  input  logic                          restore,
  input  logic [ARCH_REGS-1:0][PW-1:0]  cmt_map_next,
  output logic [PHYS_REGS-1:0]          free_vec
);
  logic [PHYS_REGS-1:0] free_q, used, alloc_oh, ret_oh;

  // lowest-numbered free register wins
  always_comb begin
    alloc_idx = '0;
    for (int i = PHYS_REGS - 1; i >= 0; i--)
      if (free_q[i]) alloc_idx = PW'(i);
  end

  assign any_free = |free_q;

  always_comb begin
    used = '0;
    for (int a = 0; a < ARCH_REGS; a++)
      used[cmt_map_next[a]] = 1'b1;
  end

  always_comb begin
    alloc_oh = '0;
    ret_oh   = '0;
    if (alloc_en) alloc_oh[alloc_idx] = 1'b1;
    if (free_en)  ret_oh[free_idx]    = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_REGS; i++)
        free_q[i] <= (i >= ARCH_REGS);
    end else if (restore) begin
      free_q <= ~used;
    end else begin
      free_q <= (free_q & ~alloc_oh) | ret_oh;
    end
  end

  assign free_vec = free_q;
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
  parameter int ARCH_REGS = rn_pkg::DEF_ARCH_REGS,
  parameter int PHYS_REGS = rn_pkg::DEF_PHYS_REGS,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  output logic          ren_ready,
  input  logic [AW-1:0] ren_src_a,
  input  logic [AW-1:0] ren_src_b,
  input  logic          ren_dst_en,
  input  logic [AW-1:0] ren_dst,
  output logic [PW-1:0] ren_psrc_a,
  output logic [PW-1:0] ren_psrc_b,
  output logic [PW-1:0] ren_pdst,
  output logic [PW-1:0] ren_pold,
  input  logic          cmt_valid,
  input  logic          cmt_dst_en,
  input  logic [AW-1:0] cmt_dst,
  input  logic [PW-1:0] cmt_pdst,
  input  logic [PW-1:0] cmt_pold,
  input  logic          flush
);
  logic                          any_free, alloc_en, cmt_we;
  logic [PW-1:0]                 alloc_idx;
  logic [PHYS_REGS-1:0]          free_vec;
  logic [ARCH_REGS-1:0][PW-1:0]  spec_map, cmt_map, cmt_map_next;

  assign ren_ready = any_free && !flush;
  assign alloc_en  = ren_valid && ren_ready && ren_dst_en;
  assign cmt_we    = cmt_valid && cmt_dst_en;
  assign ren_pdst  = alloc_idx;

  rn_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_a(ren_src_a), .rd_b(ren_src_b), .rd_d(ren_dst),
    .val_a(ren_psrc_a), .val_b(ren_psrc_b), .val_d(ren_pold),
    .spec_we(alloc_en), .spec_idx(ren_dst), .spec_val(alloc_idx),
    .cmt_we(cmt_we), .cmt_idx(cmt_dst), .cmt_val(cmt_pdst),
    .restore(flush),
    .spec_map(spec_map), .cmt_map(cmt_map), .cmt_map_next(cmt_map_next)
  );

  rn_free_list #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_en), .alloc_idx(alloc_idx), .any_free(any_free),
    .free_en(cmt_we), .free_idx(cmt_pold),
    .restore(flush), .cmt_map_next(cmt_map_next),
    .free_vec(free_vec)
  );
endmodule

// File: rtl/rn_rename_checker.sv
module rn_rename_checker #(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64,
  localparam int PW = $clog2(PHYS_REGS)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          ren_valid,
  input logic                          ren_ready,
  input logic                          ren_dst_en,
  input logic [PW-1:0]                 ren_pdst,
  input logic                          cmt_valid,
  input logic                          cmt_dst_en,
  input logic [PW-1:0]                 cmt_pold,
  input logic                          flush,
  input logic [PHYS_REGS-1:0]          free_vec,
  input logic [ARCH_REGS-1:0][PW-1:0]  spec_map,
  input logic [ARCH_REGS-1:0][PW-1:0]  cmt_map
);
  assert_alloc_was_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready && ren_dst_en) |-> free_vec[ren_pdst]);

  assert_empty_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (free_vec == '0) |-> !ren_ready);

  assert_idle_keeps_pool_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ren_valid && ren_ready && ren_dst_en) && !cmt_valid && !flush) |=> $stable(free_vec));

  assert_commit_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && cmt_dst_en) |=> free_vec[$past(cmt_pold)]);

  assert_flush_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (spec_map == cmt_map));

  assert_flush_pool_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ($countones(free_vec) == PHYS_REGS - ARCH_REGS));
endmodule

bind rn_rename_unit rn_rename_checker #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
  .ren_dst_en(ren_dst_en), .ren_pdst(ren_pdst), .cmt_valid(cmt_valid),
  .cmt_dst_en(cmt_dst_en), .cmt_pold(cmt_pold), .flush(flush),
  .free_vec(free_vec), .spec_map(spec_map), .cmt_map(cmt_map)
);

// File: tb/rn_rename_unit_bench.sv
`timescale 1ns/1ps
module rn_rename_unit_bench;
  localparam int ARCH = 32;
  localparam int PHYS = 64;
  localparam int AW = $clog2(ARCH);
  localparam int PW = $clog2(PHYS);
  localparam int QD = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 1'b0, ren_dst_en = 1'b0, cmt_valid = 1'b0, cmt_dst_en = 1'b0, flush = 1'b0;
  logic [AW-1:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0, cmt_dst = '0;
  logic [PW-1:0] cmt_pdst = '0, cmt_pold = '0;
  logic ren_ready;
  logic [PW-1:0] ren_psrc_a, ren_psrc_b, ren_pdst, ren_pold;

  always #10 clk = ~clk;

  rn_rename_unit #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) u_rn_rename_unit (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst_en(ren_dst_en), .ren_dst(ren_dst),
    .ren_psrc_a(ren_psrc_a), .ren_psrc_b(ren_psrc_b), .ren_pdst(ren_pdst), .ren_pold(ren_pold),
    .cmt_valid(cmt_valid), .cmt_dst_en(cmt_dst_en), .cmt_dst(cmt_dst),
    .cmt_pdst(cmt_pdst), .cmt_pold(cmt_pold), .flush(flush)
  );

  int checks = 0, failures = 0;
  int m_spec[ARCH];
  int m_cmt[ARCH];
  bit m_free[PHYS];
  int q_dst[QD], q_pdst[QD], q_pold[QD];
  bit q_en[QD];
  int q_head = 0, q_cnt = 0;

  function automatic int lowest_free();
    for (int i = 0; i < PHYS; i++) if (m_free[i]) return i;
    return -1;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < ARCH; i++) begin m_spec[i] = i; m_cmt[i] = i; end
    for (int i = 0; i < PHYS; i++) m_free[i] = (i >= ARCH);
    q_head = 0; q_cnt = 0;
  endtask

  task automatic step(string tag, bit v, int sa, int sb, bit de, int d, bit do_cmt, bit fl);
    bit exp_ready, cm;
    int p, idx;
    @(negedge clk);
    cm = do_cmt && (q_cnt > 0);
    ren_valid = v; ren_src_a = AW'(sa); ren_src_b = AW'(sb); ren_dst_en = de; ren_dst = AW'(d);
    cmt_valid = cm; flush = fl;
    cmt_dst_en = cm ? q_en[q_head] : 1'b0;
    cmt_dst = AW'(cm ? q_dst[q_head] : 0);
    cmt_pdst = PW'(cm ? q_pdst[q_head] : 0);
    cmt_pold = PW'(cm ? q_pold[q_head] : 0);
    #4;
    exp_ready = !fl && (lowest_free() >= 0);
    check(tag, "ready", int'(ren_ready), int'(exp_ready));
    if (v && exp_ready) begin
      check(tag, "psrc_a", int'(ren_psrc_a), m_spec[sa]);
      check(tag, "psrc_b", int'(ren_psrc_b), m_spec[sb]);
      if (de) begin
        check(tag, "pdst", int'(ren_pdst), lowest_free());
        check(tag, "pold", int'(ren_pold), m_spec[d]);
      end
    end
    // model: rename, then commit, then flush
    if (v && exp_ready) begin
      idx = (q_head + q_cnt) % QD;
      q_en[idx] = de; q_dst[idx] = d;
      if (de) begin
        p = lowest_free();
        m_free[p] = 1'b0;
        q_pdst[idx] = p; q_pold[idx] = m_spec[d];
        m_spec[d] = p;
      end else begin
        q_pdst[idx] = 0; q_pold[idx] = 0;
      end
      q_cnt++;
    end
    if (cm) begin
      if (q_en[q_head]) begin
        m_free[q_pold[q_head]] = 1'b1;
        m_cmt[q_dst[q_head]] = q_pdst[q_head];
      end
      q_head = (q_head + 1) % QD; q_cnt--;
    end
    if (fl) begin
      for (int i = 0; i < PHYS; i++) m_free[i] = 1'b1;
      for (int a = 0; a < ARCH; a++) begin m_spec[a] = m_cmt[a]; m_free[m_cmt[a]] = 1'b0; end
      q_cnt = 0;
    end
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: identity map, R2: first allocation is ARCH
    #4;
    ren_src_a = AW'(5); ren_src_b = AW'(31); ren_dst_en = 1'b1; ren_dst = AW'(0); #1;
    check("R1", "psrc_a after reset", int'(ren_psrc_a), 5);
    check("R1", "psrc_b after reset", int'(ren_psrc_b), 31);
    check("R2", "first pdst", int'(ren_pdst), ARCH);
    check("R6", "ready after reset", int'(ren_ready), 1);
    step("R2", 1, 1, 2, 1, 3, 0, 0);
    step("R2", 1, 3, 4, 1, 7, 0, 0);
    step("R3", 1, 0, 0, 1, 3, 0, 0);
    step("R4", 1, 3, 7, 1, 3, 0, 0);
    step("R5", 1, 3, 7, 0, 9, 0, 0);
    step("R5", 1, 9, 9, 1, 9, 0, 0);
    // R6: drain the pool
    for (int k = 0; k < 30; k++) step("R6", 1, k % ARCH, 3, 1, k % ARCH, 0, 0);
    check("R6", "ready empty", int'(ren_ready), 0);
    // R10: request while not ready
    step("R10", 1, 3, 7, 1, 3, 0, 0);
    step("R10", 1, 3, 7, 0, 3, 0, 0);
    // R7: commit then reuse
    step("R7", 0, 0, 0, 0, 0, 1, 0);
    step("R7", 1, 3, 3, 1, 12, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 1, 0);
    // R8: flush with same-cycle commit, then lookups
    step("R8", 1, 0, 0, 1, 1, 1, 1);
    for (int a = 0; a < ARCH; a += 2) step("R8", 1, a, a + 1, 0, 0, 0, 0);
    // R9: full pool after flush
    for (int k = 0; k < PHYS - ARCH + 1; k++) step("R9", 1, k % ARCH, 0, 1, (k * 7) % ARCH, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 1);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit v, de, cm, fl;
      v  = ($urandom % 4) != 0;
      de = ($urandom % 5) != 0;
      cm = (($urandom % 2) != 0) || (q_cnt > 200);
      fl = ($urandom % 60) == 0;
      step("RAND", v, int'($urandom % ARCH), int'($urandom % ARCH), de, int'($urandom % ARCH), cm, fl);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule